// File: doc/BRIEF.md
# PHY Interrupt Event Register Block

This block sits on the management side of an Ethernet PHY. It collects eight kinds of line event into sticky status bits and drives a single interrupt pin toward the host. The rest of the PHY delivers each event as a one-cycle pulse. Software reaches the block through a plain register port with a 5-bit address and 16-bit data. The serial management framing is decoded elsewhere, and so are the sources of the events.

One register address holds both halves of the interrupt logic. Its high byte holds the per-source enables, which are both readable and writable. Its low byte holds the latched events, which software can only read, and a read of the register empties them. A separate control register carries one bit that sets the electrical sense of the interrupt pin. A typical driver writes the enables once at bring-up. When the pin fires, the driver reads the shared register: that single access tells it which events occurred and acknowledges them.

Top module: `phy_irq_regblock`

## Requirements
- R1: A read (`reg_rd`=1) of address 0x1B returns the enables in bits 15:8 and the status bits in bits 7:0 on `reg_rdata` in the same cycle, before any clearing.
- R2: A write of address 0x1B loads `reg_wdata[15:8]` into the enables at the next clock edge. The low byte of the written data is ignored, so the status bits keep their value. Writing 0 turns off every source.
- R3: A pulse on `evt_pulse[n]` sets status bit n at the next clock edge, whatever the state of enable bit n+8. The bits map as follows: 7 jabber, 6 receive error, 5 page received, 4 parallel-detect fault, 3 partner acknowledge, 2 link down, 1 remote fault, 0 link up.
- R4: A status bit stays set until a read of address 0x1B. That read clears all eight status bits at the clock edge that ends the read cycle.
- R5: If an event pulse arrives in the same cycle as a clearing read, its status bit is set after that edge.
- R6: The interrupt is active while at least one status bit and its enable are both 1. A status bit whose enable is 0 never makes the interrupt active.
- R7: Bit 9 of the control register at address 0x1F sets the pin sense: 1 drives `irq_pin` high when the interrupt is active, and 0 drives it low when active. A read of 0x1F returns that bit in position 9 and zeros in every other position.
- R8: Reads of 0x1F or of any other address leave the status bits unchanged. Reads of addresses other than 0x1B and 0x1F return 0, and writes to those addresses change nothing.
- R9: After a synchronous reset all enables are 0, all status bits are 0 and the pin sense is active low, so `irq_pin` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while `reg_rd` is 1 |
| evt_pulse | input | 8 | One-cycle event pulses, bit n feeds status bit n |
| irq_pin | output | 1 | Interrupt pin, sense set by control bit 9 |

## Verification
Read data is combinational, so it is due in the cycle the read strobe is high. The bench samples it one nanosecond after driving the inputs at the falling edge, before the next rising edge can clear anything. Enables, status, polarity and therefore `irq_pin` all change at the first rising edge after the stimulus. The bench updates its model at that edge and compares the pin one nanosecond later, in every cycle. The collision case (R5) and the non-clearing reads (R8) are each followed by a read of 0x1B, so that the surviving status shows at the ports.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 16;
    localparam int EVT_N   = 8;
    localparam int POL_BIT = 9;

    localparam logic [ADDR_W-1:0] ADDR_EVT = 5'h1B;
    localparam logic [ADDR_W-1:0] ADDR_CFG = 5'h1F;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_EVT  = 2'd1,
        SEL_CFG  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic wr_evt;
        logic wr_cfg;
        logic rd_clr;
    } access_s;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        if (a == ADDR_EVT)      return SEL_EVT;
        else if (a == ADDR_CFG) return SEL_CFG;
        else                    return SEL_NONE;
    endfunction

    function automatic logic pin_level(input logic active, input logic high_sense);
        return high_sense ? active : ~active;
    endfunction

endpackage

// File: rtl/irq_status_latch.sv
module irq_status_latch #(
    parameter int N = phy_irq_pkg::EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] sts
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)          sts[i] <= 1'b0;
            else if (evt[i])  sts[i] <= 1'b1;
            else if (clr)     sts[i] <= 1'b0;
        end

        // R3 R5
        evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> sts[i]);

        // R4
        clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !sts[i]);

        // R4 R8
        sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (!clr && sts[i]) |=> sts[i]);
    end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
    parameter int N    = phy_irq_pkg::EVT_N,
    parameter int DW   = phy_irq_pkg::DATA_W,
    parameter int POLB = phy_irq_pkg::POL_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_evt,
    input  logic          wr_cfg,
    input  logic [DW-1:0] wdata,
    output logic [N-1:0]  en,
    output logic          pol
);

    localparam int EN_LSB = DW - N;

    always_ff @(posedge clk) begin
        if (rst) begin
            en  <= '0;
            pol <= 1'b0;
        end else begin
            if (wr_evt) en  <= wdata[EN_LSB +: N];
            if (wr_cfg) pol <= wdata[POLB];
        end
    end

    // R2 R8
    en_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_evt |=> $stable(en));

    // R9
    rst_clean_chk: assert property (@(posedge clk)
        rst |=> (en == '0 && pol == 1'b0));

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive #(
    parameter int N = phy_irq_pkg::EVT_N
) (
    input  logic [N-1:0] en,
    input  logic [N-1:0] sts,
    input  logic         pol,
    output logic         irq_pin
);
    import phy_irq_pkg::*;

    logic [N-1:0] armed;
    logic         active;

    always_comb begin
        armed   = en & sts;
        active  = |armed;
        irq_pin = pin_level(active, pol);
    end

endmodule

// File: rtl/phy_irq_regblock.sv
module phy_irq_regblock
    import phy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [EVT_N-1:0]  evt_pulse,
    output logic              irq_pin
);

    reg_sel_e         sel;
    access_s          acc;
    logic [EVT_N-1:0] en_q;
    logic [EVT_N-1:0] sts_q;
    logic             pol_q;

    always_comb begin
        sel        = decode_addr(reg_addr);
        acc.wr_evt = reg_wr && (sel == SEL_EVT);
        acc.wr_cfg = reg_wr && (sel == SEL_CFG);
        acc.rd_clr = reg_rd && (sel == SEL_EVT);
    end

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_EVT: reg_rdata = {en_q, sts_q};
            SEL_CFG: reg_rdata[POL_BIT] = pol_q;
            default: reg_rdata = '0;
        endcase
    end

    irq_cfg_regs #(.N(EVT_N), .DW(DATA_W), .POLB(POL_BIT)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .wr_evt (acc.wr_evt),
        .wr_cfg (acc.wr_cfg),
        .wdata  (reg_wdata),
        .en     (en_q),
        .pol    (pol_q)
    );

    irq_status_latch #(.N(EVT_N)) u_sts (
        .clk (clk),
        .rst (rst),
        .clr (acc.rd_clr),
        .evt (evt_pulse),
        .sts (sts_q)
    );

    irq_pin_drive #(.N(EVT_N)) u_pin (
        .en      (en_q),
        .sts     (sts_q),
        .pol     (pol_q),
        .irq_pin (irq_pin)
    );

    // R6
    no_enable_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (en_q == '0) |-> (irq_pin == ~pol_q));

endmodule

// File: tb/phy_irq_regblock_tb.sv
module phy_irq_regblock_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  evt_pulse = '0;
    logic        irq_pin;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    // reference model state
    int m_en  = 0;
    int m_sts = 0;
    int m_pol = 0;

    always #2 clk = ~clk;

    phy_irq_regblock u_dut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_pulse(evt_pulse), .irq_pin(irq_pin)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_pin();
        int active = ((m_en & m_sts) != 0) ? 1 : 0;
        return (m_pol != 0) ? active : 1 - active;
    endfunction

    function automatic int exp_read(input int a);
        if (a == 'h1B) return (m_en << 8) | m_sts;
        if (a == 'h1F) return m_pol << 9;
        return 0;
    endfunction

    // one bus cycle: drive at falling edge, check read data, model the edge, check pin
    task automatic cyc(input int a, input bit wr, input bit rd, input int wd,
                       input int ev, input string rtag);
        @(negedge clk);
        reg_addr  = a[4:0];
        reg_wr    = wr;
        reg_rd    = rd;
        reg_wdata = wd[15:0];
        evt_pulse = ev[7:0];
        #1;
        if (rd) chk(rtag, int'(reg_rdata), exp_read(a));
        @(posedge clk);
        if (wr && a == 'h1B) m_en = (wd >> 8) & 'hFF;
        if (wr && a == 'h1F) m_pol = (wd >> 9) & 1;
        if (rd && a == 'h1B) m_sts = ev & 'hFF;
        else                 m_sts = m_sts | (ev & 'hFF);
        #1;
        chk("R6 pin", int'(irq_pin), exp_pin());
        reg_wr = 1'b0; reg_rd = 1'b0; evt_pulse = '0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
                $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R9 reset state
        chk("R9 pin after reset", int'(irq_pin), 1);
        cyc('h1B, 0, 1, 0, 0, "R9 evt reg after reset");
        cyc('h1F, 0, 1, 0, 0, "R9 cfg reg after reset");

        // R3: events latch with enables off; R6: pin stays idle
        cyc('h00, 0, 0, 0, 'h05, "R3");
        chk("R6 masked pin", int'(irq_pin), 1);
        cyc('h1B, 0, 1, 0, 0, "R3 latched status");
        cyc('h1B, 0, 1, 0, 0, "R4 cleared by read");

        // R2: write loads enables, low byte ignored
        cyc('h00, 0, 0, 0, 'h40, "R2");
        cyc('h1B, 1, 0, 'hA5FF, 0, "R2");
        cyc('h1B, 0, 1, 0, 0, "R2 enables loaded status kept");

        // R6 active low assertion then clear
        cyc('h00, 0, 0, 0, 'h01, "R6");
        chk("R6 pin active low", int'(irq_pin), 0);
        cyc('h1B, 0, 1, 0, 0, "R4 read before clear");
        chk("R4 pin released", int'(irq_pin), 1);

        // R8: other reads do not clear, other writes ignored
        cyc('h00, 0, 0, 0, 'h80, "R8");
        cyc('h1F, 0, 1, 0, 0, "R8 cfg read");
        cyc('h02, 0, 1, 0, 0, "R8 other read");
        cyc('h02, 1, 0, 'hFFFF, 0, "R8");
        cyc('h1B, 0, 1, 0, 0, "R8 status survived");

        // R7 polarity high
        cyc('h1F, 1, 0, 'h0200, 0, "R7");
        chk("R7 idle high sense", int'(irq_pin), 0);
        cyc('h00, 0, 0, 0, 'h04, "R7");
        chk("R7 active high", int'(irq_pin), 1);
        cyc('h1F, 0, 1, 0, 0, "R7 cfg readback");
        cyc('h1B, 0, 1, 0, 0, "R4");

        // R5 event coinciding with clearing read
        cyc('h00, 0, 0, 0, 'h02, "R5");
        cyc('h1B, 0, 1, 0, 'h20, "R5 read during event");
        chk("R5 pin", int'(irq_pin), 1);
        cyc('h1B, 0, 1, 0, 0, "R5 event kept");

        // R2 writing zero disables every source
        cyc('h00, 0, 0, 0, 'hFF, "R2");
        cyc('h1B, 1, 0, 'h0000, 0, "R2 zero enables");
        chk("R2 pin off", int'(irq_pin), 0);
        cyc('h1B, 0, 1, 0, 0, "R1 read");

        // mixed traffic against the model (R1, R6)
        for (int k = 0; k < 3000; k++) begin
            int sel = int'($urandom_range(0, 3));
            int a   = (sel == 0) ? 'h1B : (sel == 1) ? 'h1F : (sel == 2) ? 'h1B : int'($urandom_range(0, 31));
            bit wr  = ($urandom_range(0, 7) == 0);
            bit rd  = !wr && ($urandom_range(0, 3) == 0);
            int wd  = int'($urandom_range(0, 65535));
            int ev  = ($urandom_range(0, 2) == 0) ? (1 << $urandom_range(0, 7)) : 0;
            cyc(a, wr, rd, wd, ev, "R1 mixed read");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule